// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a NOR-style flash model. Each clock it samples five active-low control pins and classifies the clock as a write bus cycle, a read bus cycle, or an idle state (standby, output disable or reset). On a write it takes an 8-bit command from the low data byte. It sequences one-cycle and two-cycle commands, and hands word-program and block-erase jobs to a write engine. The engine is modelled as a deterministic down-counter that updates a small on-chip array.

Reads return one of three sources: array words, the status register or identifier codes. The source is chosen by the current read mode. While the engine is busy, every read returns status, and the only command honoured is the read-status command. The full command set comes back once the ready bit (status bit 7) is high again. A low level on the hardware reset pin, or the synchronous `rst`, cancels everything and returns the controller to read-array mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write bus cycle is any clock in which `chip_sel_n`=0, `wr_en_n`=0, `out_en_n`=1 and `hw_rst_n`=1. Its command byte is `dq_in[7:0]`, and its second-cycle data is the full `dq_in` word.
- R2: A read bus cycle is any clock in which `chip_sel_n`=0, `addr_vld_n`=0, `out_en_n`=0, `wr_en_n`=1 and `hw_rst_n`=1. On the clock after a read cycle, `dq_oe`=1 and `dq_out` carries the read data. On the clock after any other clock, `dq_oe`=0 and `dq_out`=0.
- R3: `rst`=1 or `hw_rst_n`=0 puts the controller in read-array mode. It clears the error bits, cancels any half-entered command, stops the engine (status reads 0x80) and forces `dq_oe` low on the next clock. This holds whatever the other pins are doing.
- R4: Command 0xFF selects read-array mode, 0x70 selects read-status mode and 0x90 selects identifier mode. In identifier mode, address bit 0 = 0 returns `MFR_CODE` and bit 0 = 1 returns `DEV_CODE`. Any code that is not listed leaves the mode unchanged.
- R5: Command 0x40 followed by a data write programs that word at the second cycle's address. The ready bit is low for exactly `PROG_CYCLES` clocks after the second write.
- R6: Command 0x20 followed by 0xD0 fills every word of the block selected by `addr[ADDR_W-1:BLK_W]` with all ones. The ready bit is low for exactly 2^`BLK_W` clocks.
- R7: Command 0x20 followed by any other byte starts no erase and sets status bits 5 and 4. A read cycle between the first and second cycle of 0x40 or 0x20 cancels the sequence without starting the engine. The next write is then decoded as a new first cycle.
- R8: While the engine is busy, every read returns the status register, whatever the mode or address. Every write other than 0x70 is ignored.
- R9: Command 0x50 clears status bits 5 and 4 and leaves the read mode unchanged.
- R10: The status word has the ready flag in bit 7 and the error flags in bits 5 and 4. All other bits read 0, and status bit n appears on `dq_out[n]`.
- R11: After the first cycle of 0x40 or 0x20, the controller is in read-status mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr_vld_n | input | 1 | Address valid, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, overrides all others |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data / command byte in the low 8 bits |
| dq_out | output | DATA_W | Read data, 0 when not driving |
| dq_oe | output | 1 | Data bus drive enable (low = high impedance) |

## Verification
On every cycle the assertions check four things. A clock that is not a read is followed by a released bus. The hardware reset pin stops the engine and releases the bus. The engine never starts except on a write cycle. A read taken while busy shows a status word with its unused bits at zero and a ready bit that agrees with the engine. The rest can only be shown by the bench's scenarios: that array contents follow programs and erases, that half-entered or wrong sequences leave the array untouched and set the errors, and that mode changes and identifier codes are right.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } rd_mode_t;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_PROG  = 2'd1,
    PEND_ERASE = 2'd2
  } pend_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_PROGRAM    = 8'h40;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
endpackage

// File: rtl/fcc_bus_decode.sv
module fcc_bus_decode (
  input  logic chip_sel_n,
  input  logic wr_en_n,
  input  logic out_en_n,
  input  logic addr_vld_n,
  input  logic hw_rst_n,
  output logic wr_cyc,
  output logic rd_cyc,
  output logic pin_clr
);
  // reset pin wins over every other control input
  assign pin_clr = !hw_rst_n;
  assign wr_cyc  = hw_rst_n && !chip_sel_n && !wr_en_n && out_en_n;
  assign rd_cyc  = hw_rst_n && !chip_sel_n && !addr_vld_n && !out_en_n && wr_en_n;
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fcc_write_engine.sv
module fcc_write_engine #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BLK_W       = 4,
  parameter int PROG_CYCLES = 6
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int BLK_WORDS = 2 ** BLK_W;
  localparam int MAX_LEN   = (PROG_CYCLES > BLK_WORDS) ? PROG_CYCLES : BLK_WORDS;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0]  cnt;
  logic              is_erase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      busy     <= 1'b0;
      cnt      <= '0;
      is_erase <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start_prog) begin
      busy     <= 1'b1;
      is_erase <= 1'b0;
      cnt      <= CNT_W'(PROG_CYCLES - 1);
      addr_q   <= addr_in;
      data_q   <= data_in;
    end else if (start_erase) begin
      busy     <= 1'b1;
      is_erase <= 1'b1;
      cnt      <= CNT_W'(BLK_WORDS - 1);
      addr_q   <= addr_in;
    end
  end

  // erase writes one word per clock, program writes once at the end
  assign mem_we    = busy && (is_erase || cnt == '0);
  assign mem_waddr = is_erase ? {addr_q[ADDR_W-1:BLK_W], cnt[BLK_W-1:0]} : addr_q;
  assign mem_wdata = is_erase ? '1 : data_q;
endmodule

// File: rtl/fcc_sequencer.sv
module fcc_sequencer
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       wr_cyc,
  input  logic       rd_cyc,
  input  logic [7:0] cmd,
  input  logic       eng_busy,
  output logic       start_prog,
  output logic       start_erase,
  output rd_mode_t   mode,
  output logic [7:0] status
);
  pend_t      pend;
  logic [1:0] err;

  assign start_prog  = wr_cyc && !eng_busy && (pend == PEND_PROG);
  assign start_erase = wr_cyc && !eng_busy && (pend == PEND_ERASE) && (cmd == CMD_CONFIRM);
  assign status      = {!eng_busy, 1'b0, err, 4'b0000};

  always_ff @(posedge clk) begin
    if (clr) begin
      mode <= MODE_ARRAY;
      pend <= PEND_NONE;
      err  <= 2'b00;
    end else if (wr_cyc) begin
      if (eng_busy) begin
        if (cmd == CMD_READ_STAT) mode <= MODE_STATUS;
      end else begin
        unique case (pend)
          PEND_PROG: pend <= PEND_NONE;
          PEND_ERASE: begin
            pend <= PEND_NONE;
            mode <= MODE_STATUS;
            if (cmd != CMD_CONFIRM) err <= 2'b11;
          end
          default: begin
            case (cmd)
              CMD_READ_ARRAY: mode <= MODE_ARRAY;
              CMD_READ_STAT:  mode <= MODE_STATUS;
              CMD_READ_ID:    mode <= MODE_IDENT;
              CMD_CLR_STAT:   err  <= 2'b00;
              CMD_PROGRAM: begin
                pend <= PEND_PROG;
                mode <= MODE_STATUS;
              end
              CMD_ERASE: begin
                pend <= PEND_ERASE;
                mode <= MODE_STATUS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end else if (rd_cyc) begin
      pend <= PEND_NONE;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 16,
  parameter int          BLK_W       = 4,
  parameter int          PROG_CYCLES = 6,
  parameter logic [15:0] MFR_CODE    = 16'h00A5,
  parameter logic [15:0] DEV_CODE    = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic              addr_vld_n,
  input  logic              hw_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              wr_cyc, rd_cyc, pin_clr, clr;
  logic              eng_busy, start_prog, start_erase;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, arr_q;
  rd_mode_t          mode, sel_q;
  logic [7:0]        status;
  logic              id_dev_q;

  assign clr = rst || pin_clr;

  fcc_bus_decode u_dec (
    .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n), .out_en_n(out_en_n),
    .addr_vld_n(addr_vld_n), .hw_rst_n(hw_rst_n),
    .wr_cyc(wr_cyc), .rd_cyc(rd_cyc), .pin_clr(pin_clr)
  );

  fcc_sequencer u_seq (
    .clk(clk), .clr(clr), .wr_cyc(wr_cyc), .rd_cyc(rd_cyc), .cmd(dq_in[7:0]),
    .eng_busy(eng_busy), .start_prog(start_prog), .start_erase(start_erase),
    .mode(mode), .status(status)
  );

  fcc_write_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_eng (
    .clk(clk), .clr(clr), .start_prog(start_prog), .start_erase(start_erase),
    .addr_in(addr), .data_in(dq_in), .busy(eng_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  fcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr), .rdata(arr_q)
  );

  // read source is fixed at the read clock; a busy engine forces status
  always_ff @(posedge clk) begin
    if (clr) begin
      dq_oe    <= 1'b0;
      sel_q    <= MODE_ARRAY;
      id_dev_q <= 1'b0;
    end else begin
      dq_oe <= rd_cyc;
      if (rd_cyc) begin
        sel_q    <= eng_busy ? MODE_STATUS : mode;
        id_dev_q <= addr[0];
      end
    end
  end

  always_comb begin
    dq_out = '0;
    if (dq_oe) begin
      case (sel_q)
        MODE_ARRAY:  dq_out = arr_q;
        MODE_STATUS: dq_out = DATA_W'(status);
        default:     dq_out = id_dev_q ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
      endcase
    end
  end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_sel_n,
  input logic              wr_en_n,
  input logic              out_en_n,
  input logic              addr_vld_n,
  input logic              hw_rst_n,
  input logic              eng_busy,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);
  logic rd_pins, wr_pins;
  assign rd_pins = hw_rst_n && !chip_sel_n && !addr_vld_n && !out_en_n && wr_en_n;
  assign wr_pins = hw_rst_n && !chip_sel_n && !wr_en_n && out_en_n;

  // R2
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_pins |=> (!dq_oe && dq_out == '0));

  // R3
  pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !hw_rst_n |=> (!dq_oe && !eng_busy));

  // R5
  start_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(wr_pins));

  // R10
  status_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pins && eng_busy) |=> (dq_out[DATA_W-1:8] == '0 && !dq_out[6]
                               && dq_out[3:0] == 4'h0 && dq_out[5] == dq_out[4]));

  // R8
  busy_read_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pins && eng_busy) |=> (dq_oe && (dq_out[7] == !eng_busy)));
endmodule

bind flash_cmd_ctrl fcc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
  .out_en_n(out_en_n), .addr_vld_n(addr_vld_n), .hw_rst_n(hw_rst_n),
  .eng_busy(eng_busy), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int AW = 8, DW = 16, BW = 4, PC = 6;
  localparam logic [15:0] MFR = 16'h00A5, DEV = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_sel_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1, addr_vld_n = 1'b1, hw_rst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(BW), .PROG_CYCLES(PC),
                   .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
    .out_en_n(out_en_n), .addr_vld_n(addr_vld_n), .hw_rst_n(hw_rst_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R3";

  // behavioural reference: 0 array, 1 status, 2 ident; pend 0 none, 1 prog, 2 erase
  logic [15:0] mem_m [256];
  int m_mode = 0, m_pend = 0, m_left = 0;
  bit m_erase = 0, m_oe = 0, ob = 0, w = 0, r = 0;
  logic [1:0]  m_err = 0;
  logic [7:0]  m_addr = 0, m_st = 0;
  logic [15:0] m_data = 0, m_dq = 0;

  always @(posedge clk) begin
    ob = (m_left > 0);
    if (rst || !hw_rst_n) begin
      m_mode = 0; m_pend = 0; m_left = 0; m_err = 0; m_oe = 0; m_dq = 0;
    end else begin
      w = !chip_sel_n && !wr_en_n && out_en_n;
      r = !chip_sel_n && !addr_vld_n && !out_en_n && wr_en_n;
      if (m_left > 0) begin
        if (m_erase) mem_m[{m_addr[7:4], 4'(m_left - 1)}] = 16'hFFFF;
        m_left--;
        if (!m_erase && m_left == 0) mem_m[m_addr] = m_data;
      end
      if (w) begin
        if (ob) begin
          if (dq_in[7:0] == 8'h70) m_mode = 1;
        end else if (m_pend == 1) begin
          m_pend = 0; m_left = PC; m_erase = 0; m_addr = addr; m_data = dq_in;
        end else if (m_pend == 2) begin
          m_pend = 0; m_mode = 1;
          if (dq_in[7:0] == 8'hD0) begin m_left = 16; m_erase = 1; m_addr = addr; end
          else m_err = 2'b11;
        end else begin
          case (dq_in[7:0])
            8'hFF: m_mode = 0;
            8'h70: m_mode = 1;
            8'h90: m_mode = 2;
            8'h50: m_err = 2'b00;
            8'h40: begin m_pend = 1; m_mode = 1; end
            8'h20: begin m_pend = 2; m_mode = 1; end
            default: ;
          endcase
        end
      end
      m_st = {(m_left == 0), 1'b0, m_err, 4'b0000};
      if (r) begin
        m_pend = 0;
        m_oe = 1;
        if (ob || m_mode == 1) m_dq = {8'h00, m_st};
        else if (m_mode == 0)  m_dq = mem_m[addr];
        else                   m_dq = addr[0] ? DEV : MFR;
      end else begin
        m_oe = 0; m_dq = 0;
      end
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    cycles++;
    checks++;
    if (dq_oe !== m_oe || dq_out !== m_dq) begin
      fails++;
      $display("FAIL %s cycle %0d: oe=%0b dq=%h expected oe=%0b dq=%h",
               cur_req, cycles, dq_oe, dq_out, m_oe, m_dq);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle_pins();
    chip_sel_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1; addr_vld_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    idle_pins(); chip_sel_n = 1'b0; wr_en_n = 1'b0; addr = a; dq_in = d;
    @(negedge clk);
    idle_pins();
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk);
    idle_pins(); chip_sel_n = 1'b0; addr_vld_n = 1'b0; out_en_n = 1'b0; addr = a;
    @(negedge clk);
    idle_pins();
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_word(input string req, input logic [15:0] exp);
    // called one negedge after a read cycle
    checks++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      fails++;
      $display("FAIL %s: actual oe=%0b dq=%h expected oe=1 dq=%h", req, dq_oe, dq_out, exp);
    end
  endtask

  task automatic rd_expect(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    idle_pins(); chip_sel_n = 1'b0; addr_vld_n = 1'b0; out_en_n = 1'b0; addr = a;
    @(negedge clk);
    idle_pins();
    expect_word(req, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 'x;
    wait_clks(4);
    cur_req = "R3";
    checks++;
    if (dq_oe !== 1'b0) begin fails++; $display("FAIL R3 reset: oe=%0b expected 0", dq_oe); end
    rst = 1'b0;
    wait_clks(2);

    // R6: erase block 0, poll status while busy (R8)
    cur_req = "R6";
    bus_wr(8'h05, 16'h0020);
    cur_req = "R11";
    rd_expect("R11", 8'h05, 16'h0080);
    bus_wr(8'h05, 16'h0020);
    bus_wr(8'h05, 16'h00D0);
    cur_req = "R8";
    for (int i = 0; i < 17; i++) bus_rd(8'h03);
    cur_req = "R10";
    rd_expect("R10", 8'h00, 16'h0080);
    cur_req = "R4";
    bus_wr(8'h00, 16'h00FF);
    for (int i = 0; i < 8; i++) rd_expect("R6", 8'(i), 16'hFFFF);

    // R5: program a word; during busy a 0xFF and a second 0x40 are ignored (R8)
    cur_req = "R5";
    bus_wr(8'h00, 16'h0040);
    bus_wr(8'h03, 16'h1234);
    cur_req = "R8";
    bus_wr(8'h00, 16'h00FF);
    rd_expect("R8", 8'h03, 16'h0000);
    bus_wr(8'h00, 16'h0040);
    wait_clks(4);
    rd_expect("R5", 8'h03, 16'h0080);
    bus_wr(8'h07, 16'h5555);
    rd_expect("R8", 8'h07, 16'h0080);
    cur_req = "R4";
    bus_wr(8'h00, 16'h00FF);
    rd_expect("R5", 8'h03, 16'h1234);
    rd_expect("R5", 8'h07, 16'hFFFF);

    // R4: identifier mode and an unknown code
    bus_wr(8'h00, 16'h0090);
    rd_expect("R4", 8'h00, MFR);
    rd_expect("R4", 8'h01, DEV);
    bus_wr(8'h00, 16'h0033);
    rd_expect("R4", 8'h02, MFR);
    cur_req = "R1";
    bus_wr(8'h00, 16'hAB70);
    rd_expect("R1", 8'h02, 16'h0080);

    // R7: bad erase confirm, then R9 clear
    cur_req = "R7";
    bus_wr(8'h00, 16'h0020);
    bus_wr(8'h02, 16'h0011);
    rd_expect("R7", 8'h02, 16'h00B0);
    cur_req = "R9";
    bus_wr(8'h00, 16'h0050);
    rd_expect("R9", 8'h02, 16'h0080);
    cur_req = "R7";
    bus_wr(8'h00, 16'h00FF);
    rd_expect("R7", 8'h02, 16'hFFFF);

    // R7: read cancels a half-entered program
    bus_wr(8'h00, 16'h0040);
    bus_rd(8'h06);
    bus_wr(8'h06, 16'hABCD);
    rd_expect("R7", 8'h06, 16'h0080);
    bus_wr(8'h00, 16'h00FF);
    rd_expect("R7", 8'h06, 16'hFFFF);

    // R2: standby and output disable release the bus
    cur_req = "R2";
    @(negedge clk);
    idle_pins(); addr_vld_n = 1'b0; out_en_n = 1'b0; chip_sel_n = 1'b1;
    @(negedge clk);
    idle_pins(); chip_sel_n = 1'b0; addr_vld_n = 1'b0; out_en_n = 1'b1;
    @(negedge clk);
    idle_pins();
    checks++;
    if (dq_oe !== 1'b0) begin fails++; $display("FAIL R2: oe=%0b expected 0", dq_oe); end

    // R3: hardware reset pin during an erase of block 1
    cur_req = "R3";
    bus_wr(8'h10, 16'h0020);
    bus_wr(8'h10, 16'h00D0);
    wait_clks(3);
    @(negedge clk);
    hw_rst_n = 1'b0; chip_sel_n = 1'b0; wr_en_n = 1'b0; dq_in = 16'h0090;
    @(negedge clk);
    hw_rst_n = 1'b1; idle_pins();
    rd_expect("R3", 8'h03, 16'h1234);
    bus_wr(8'h00, 16'h0070);
    rd_expect("R3", 8'h00, 16'h0080);

    wait_clks(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule